// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds three transmit mailboxes for a CAN controller and decides which mailbox goes next to a downstream frame transmitter. The host loads a mailbox with an 11-bit standard identifier, a 4-bit length code and two 32-bit data words. It then hands the mailbox over by setting its request. The block reports which mailboxes are empty. It also returns a free-mailbox code, so the host always knows where it can write next.

A three-state machine drives the downstream side. The states are `S_IDLE`, `S_OFFER` and `S_BUSY`. The *pick* transition (`S_IDLE` to `S_OFFER`) fires when any request is pending. In that transition the scheduler latches the chosen mailbox. The *accept* transition (`S_OFFER` to `S_BUSY`) fires when `tx_ready` is seen while `tx_valid` is high. The *release* transition (`S_BUSY` to `S_IDLE`) fires on `tx_done`, and it frees the mailbox. One configuration bit selects the scheduling rule. With the bit low, the rule is identifier priority. With the bit high, the rule is request arrival order, which a pairwise age matrix keeps track of.

Top module: `can_tx_sched`

## Requirements
- R1: After reset all three mailboxes are empty (`mb_empty` = 3'b111), `free_code` is 0 and `tx_valid` is low.
- R2: Bit i of `mb_empty` is 1 exactly when mailbox i has no pending or in-progress request. A mailbox that is offered or being sent reads as not empty.
- R3: `free_code` gives the lowest-numbered empty mailbox as 0, 1 or 2. It reads 3 when no mailbox is empty.
- R4: `wr_en` stores `wr_id`, `wr_dlc`, `wr_data_lo` and `wr_data_hi` into mailbox `wr_idx` when that mailbox is empty. `req_en` on an empty mailbox `req_idx` sets its request, so its `mb_empty` bit reads 0 one clock later. The stored fields appear unchanged on `tx_id`, `tx_dlc`, `tx_data_lo` and `tx_data_hi` when the mailbox is offered.
- R5: A write or request aimed at a mailbox that is not empty is ignored. Its stored fields and its flags are unchanged.
- R6: With `cfg_fifo_order` = 0, the pick chooses the pending mailbox with the numerically lowest identifier. Equal identifiers go to the lowest mailbox index.
- R7: With `cfg_fifo_order` = 1, the pick chooses the pending mailbox whose request was set earliest, whatever its identifier.
- R8: Once `tx_valid` is high, it stays high with the same `tx_idx` and fields until a clock edge where `tx_ready` is high. After that edge `tx_valid` is low until the mailbox has been released.
- R9: `tx_done` while a frame is being sent clears that mailbox's request, so its `mb_empty` bit is 1 one clock later. `tx_done` at any other time changes nothing.
- R10: The scheduling rule is sampled only at the pick. The rule and selection are evaluated over all requests pending in the cycle after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_order | input | 1 | 0: identifier priority, 1: request order |
| wr_en | input | 1 | Write mailbox fields |
| wr_idx | input | 2 | Mailbox index to write |
| wr_id | input | 11 | Standard identifier |
| wr_dlc | input | 4 | Length code |
| wr_data_lo | input | 32 | Data bytes 0 to 3 |
| wr_data_hi | input | 32 | Data bytes 4 to 7 |
| req_en | input | 1 | Set transmit request |
| req_idx | input | 2 | Mailbox index to request |
| mb_empty | output | 3 | Per-mailbox empty flags |
| free_code | output | 2 | Lowest empty mailbox, 3 = none |
| tx_valid | output | 1 | A frame is offered |
| tx_ready | input | 1 | Transmitter takes the offered frame |
| tx_idx | output | 2 | Mailbox being offered or sent |
| tx_id | output | 11 | Offered identifier |
| tx_dlc | output | 4 | Offered length code |
| tx_data_lo | output | 32 | Offered low data word |
| tx_data_hi | output | 32 | Offered high data word |
| tx_done | input | 1 | Transmitter finished the current frame |

## Verification
The directed cases load two mailboxes with different identifiers while a third is in flight. The lower identifier sitting in the higher slot separates priority picking from index picking. A pair with equal identifiers requested in reverse index order shows that ties go to the lower index. Switching to request order with a younger low identifier shows that age overrides identifier. Random rounds mix both modes, writes into occupied mailboxes and requests in any order, and a bench model predicts each pick, each set of flags and each payload.

// File: rtl/can_txsch_pkg.sv
package can_txsch_pkg;
    parameter int NUM_MB = 3;
    parameter int ID_W   = 11;
    parameter int DLC_W  = 4;
    parameter int WORD_W = 32;
    parameter int IDX_W  = $clog2(NUM_MB + 1);
    parameter logic [IDX_W-1:0] NO_FREE = IDX_W'(NUM_MB);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } mb_entry_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_OFFER = 2'd1,
        S_BUSY  = 2'd2
    } sched_state_e;
endpackage

// File: rtl/cts_mb_store.sv
module cts_mb_store
    import can_txsch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  mb_entry_t             wr_entry,
    input  logic                  req_en,
    input  logic [IDX_W-1:0]      req_idx,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx,
    output mb_entry_t [NUM_MB-1:0] entries,
    output logic [NUM_MB-1:0]     req_q,
    output logic [NUM_MB-1:0]     req_new,
    output logic [IDX_W-1:0]      free_code
);
    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic hit_wr, hit_req, hit_clr;
        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(i)) && !req_q[i];
        assign hit_req = req_en && (req_idx == IDX_W'(i)) && !req_q[i];
        assign hit_clr = clr_en && (clr_idx == IDX_W'(i));
        assign req_new[i] = hit_req;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[i] <= '0;
                req_q[i]   <= 1'b0;
            end else begin
                if (hit_wr)       entries[i] <= wr_entry;
                if (hit_clr)      req_q[i]   <= 1'b0;
                else if (hit_req) req_q[i]   <= 1'b1;
            end
        end

        AST_LOCKED_MB: assert property (@(posedge clk) disable iff (!rst_n)
            (req_q[i] && !hit_clr && wr_en && wr_idx == IDX_W'(i)) |=> $stable(entries[i])); // R5
    end

    always_comb begin
        free_code = NO_FREE;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (!req_q[i]) free_code = IDX_W'(i);
        end
    end

    AST_FREE_CODE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (free_code != NO_FREE) |-> !req_q[free_code]); // R3
endmodule

// File: rtl/cts_order.sv
module cts_order
    import can_txsch_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_MB-1:0]                req_new,
    input  logic [NUM_MB-1:0]                req_q,
    output logic [NUM_MB-1:0][NUM_MB-1:0]    older
);
    // older[a][b] = 1: mailbox a was requested before mailbox b
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int k = 0; k < NUM_MB; k++) begin
                if (req_new[k]) begin
                    for (int j = 0; j < NUM_MB; j++) begin
                        older[k][j] <= 1'b0;
                        if (j != k) older[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    for (genvar a = 0; a < NUM_MB; a++) begin : g_a
        for (genvar b = a + 1; b < NUM_MB; b++) begin : g_b
            AST_AGE_ANTISYM: assert property (@(posedge clk) disable iff (!rst_n)
                (req_q[a] && req_q[b]) |-> (older[a][b] != older[b][a])); // R7
        end
    end
endmodule

// File: rtl/cts_pick.sv
module cts_pick
    import can_txsch_pkg::*;
(
    input  logic                          fifo_mode,
    input  logic [NUM_MB-1:0]             pend,
    input  mb_entry_t [NUM_MB-1:0]        entries,
    input  logic [NUM_MB-1:0][NUM_MB-1:0] older,
    output logic                          sel_vld,
    output logic [IDX_W-1:0]              sel_idx
);
    logic [IDX_W-1:0] pri_idx, ord_idx;
    logic [ID_W-1:0]  best_id;
    logic             pri_found, ord_found, is_oldest;

    always_comb begin
        pri_idx   = '0;
        best_id   = '1;
        pri_found = 1'b0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i] && (!pri_found || entries[i].id < best_id)) begin
                pri_found = 1'b1;
                best_id   = entries[i].id;
                pri_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        ord_idx   = '0;
        ord_found = 1'b0;
        is_oldest = 1'b0;
        for (int i = 0; i < NUM_MB; i++) begin
            is_oldest = pend[i];
            for (int j = 0; j < NUM_MB; j++) begin
                if (j != i && pend[j] && older[j][i]) is_oldest = 1'b0;
            end
            if (is_oldest && !ord_found) begin
                ord_found = 1'b1;
                ord_idx   = IDX_W'(i);
            end
        end
    end

    assign sel_vld = |pend;
    assign sel_idx = fifo_mode ? ord_idx : pri_idx;
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_txsch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fifo_order,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic [10:0]       wr_id,
    input  logic [3:0]        wr_dlc,
    input  logic [31:0]       wr_data_lo,
    input  logic [31:0]       wr_data_hi,
    input  logic              req_en,
    input  logic [1:0]        req_idx,
    output logic [2:0]        mb_empty,
    output logic [1:0]        free_code,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [1:0]        tx_idx,
    output logic [10:0]       tx_id,
    output logic [3:0]        tx_dlc,
    output logic [31:0]       tx_data_lo,
    output logic [31:0]       tx_data_hi,
    input  logic              tx_done
);
    sched_state_e                  state_q, state_d;
    logic [IDX_W-1:0]              cur_q;
    mb_entry_t [NUM_MB-1:0]        entries;
    logic [NUM_MB-1:0]             req_q, req_new;
    logic [NUM_MB-1:0][NUM_MB-1:0] older;
    logic                          sel_vld, clr_en;
    logic [IDX_W-1:0]              sel_idx;
    mb_entry_t                     wr_entry, cur_entry;

    assign wr_entry = '{id: wr_id, dlc: wr_dlc, lo: wr_data_lo, hi: wr_data_hi};
    assign clr_en   = (state_q == S_BUSY) && tx_done;

    cts_mb_store u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .req_en(req_en), .req_idx(req_idx),
        .clr_en(clr_en), .clr_idx(cur_q),
        .entries(entries), .req_q(req_q), .req_new(req_new),
        .free_code(free_code)
    );

    cts_order u_order (
        .clk(clk), .rst_n(rst_n),
        .req_new(req_new), .req_q(req_q), .older(older)
    );

    cts_pick u_pick (
        .fifo_mode(cfg_fifo_order), .pend(req_q), .entries(entries),
        .older(older), .sel_vld(sel_vld), .sel_idx(sel_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (sel_vld)  state_d = S_OFFER;  // pick
            S_OFFER: if (tx_ready) state_d = S_BUSY;   // accept
            S_BUSY:  if (tx_done)  state_d = S_IDLE;   // release
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && sel_vld) cur_q <= sel_idx;
        end
    end

    always_comb begin
        cur_entry  = entries[cur_q];
        tx_valid   = (state_q == S_OFFER);
        tx_idx     = cur_q;
        tx_id      = cur_entry.id;
        tx_dlc     = cur_entry.dlc;
        tx_data_lo = cur_entry.lo;
        tx_data_hi = cur_entry.hi;
        mb_empty   = ~req_q;
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && tx_idx == $past(tx_idx))); // R8
    AST_NO_REOFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid); // R8
    AST_OFFER_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mb_empty[tx_idx]); // R2
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> mb_empty[$past(cur_q)]); // R9
endmodule

// File: tb/can_tx_sched_tb_top.sv
module can_tx_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_order = 1'b0;
    logic        wr_en = 1'b0, req_en = 1'b0, tx_ready = 1'b0, tx_done = 1'b0;
    logic [1:0]  wr_idx = '0, req_idx = '0;
    logic [10:0] wr_id = '0;
    logic [3:0]  wr_dlc = '0;
    logic [31:0] wr_data_lo = '0, wr_data_hi = '0;
    logic [2:0]  mb_empty;
    logic [1:0]  free_code, tx_idx;
    logic        tx_valid;
    logic [10:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [31:0] tx_data_lo, tx_data_hi;

    always #4 clk = ~clk; // 125 MHz

    can_tx_sched dut_i (.*);

    int n_checks = 0, n_errors = 0, cycles = 0;
    bit m_req [3];
    logic [10:0] m_id [3];
    logic [3:0]  m_dlc [3];
    logic [31:0] m_lo [3], m_hi [3];
    int m_seq [3];
    int seq_ctr = 0;
    int m_cur = -1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_empty();
        for (int i = 0; i < 3; i++) exp_empty[i] = !m_req[i];
    endfunction

    function automatic logic [1:0] exp_free();
        exp_free = 2'd3;
        for (int i = 2; i >= 0; i--) if (!m_req[i]) exp_free = 2'(i);
    endfunction

    function automatic int exp_pick(bit fifo);
        int best = -1;
        for (int i = 0; i < 3; i++) begin
            if (m_req[i] && i != m_cur) begin
                if (best < 0) best = i;
                else if (fifo && m_seq[i] < m_seq[best]) best = i;
                else if (!fifo && m_id[i] < m_id[best]) best = i;
            end
        end
        return best;
    endfunction

    task automatic write_mb(int idx, logic [10:0] id, logic [3:0] dlc,
                            logic [31:0] lo, logic [31:0] hi, bit req);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_id = id; wr_dlc = dlc;
        wr_data_lo = lo; wr_data_hi = hi;
        req_en = req; req_idx = 2'(idx);
        if (!m_req[idx]) begin
            m_id[idx] = id; m_dlc[idx] = dlc; m_lo[idx] = lo; m_hi[idx] = hi;
            if (req) begin m_req[idx] = 1'b1; m_seq[idx] = seq_ctr++; end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; req_en = 1'b0;
        chk("R2/R4/R5 mb_empty after write", 32'(mb_empty), 32'(exp_empty()));
        chk("R3 free_code after write", 32'(free_code), 32'(exp_free()));
    endtask

    task automatic accept_frame();
        int e, w;
        e = exp_pick(cfg_fifo_order);
        w = 0;
        while (!tx_valid && w < 8) begin @(negedge clk); w++; end
        chk("R8 tx_valid rises after pick", 32'(tx_valid), 32'd1);
        if (cfg_fifo_order) chk("R7 request-order pick", 32'(tx_idx), 32'(e));
        else                chk("R6 priority pick", 32'(tx_idx), 32'(e));
        chk("R4/R5 tx_id", 32'(tx_id), 32'(m_id[e]));
        chk("R4/R5 tx_dlc", 32'(tx_dlc), 32'(m_dlc[e]));
        chk("R4/R5 tx_data_lo", tx_data_lo, m_lo[e]);
        chk("R4/R5 tx_data_hi", tx_data_hi, m_hi[e]);
        chk("R2 offered mailbox not empty", 32'(mb_empty), 32'(exp_empty()));
        @(negedge clk);
        chk("R8 valid held without ready", 32'({tx_valid, tx_idx}), 32'({1'b1, 2'(e)}));
        tx_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R8 valid low after accept", 32'(tx_valid), 32'd0);
        m_cur = e;
    endtask

    task automatic release_frame();
        @(negedge clk);
        tx_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_done = 1'b0;
        if (m_cur >= 0) m_req[m_cur] = 1'b0;
        m_cur = -1;
        chk("R9 mailbox freed on done", 32'(mb_empty), 32'(exp_empty()));
        chk("R3 free_code after done", 32'(free_code), 32'(exp_free()));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 3; i++) begin
            m_req[i] = 0; m_id[i] = '0; m_dlc[i] = '0; m_lo[i] = '0; m_hi[i] = '0; m_seq[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mb_empty", 32'(mb_empty), 32'h7);
        chk("R1 reset free_code", 32'(free_code), 32'd0);
        chk("R1 reset tx_valid", 32'(tx_valid), 32'd0);

        // directed: priority with the lower id in the higher slot
        cfg_fifo_order = 1'b0;
        write_mb(0, 11'h102, 4'd2, 32'h0000_0201, 32'h0, 1'b1);
        accept_frame();
        write_mb(1, 11'h200, 4'd8, 32'h1111_2222, 32'h3333_4444, 1'b1);
        write_mb(2, 11'h100, 4'd1, 32'h0000_00AA, 32'h0, 1'b1);
        chk("R3 none free", 32'(free_code), 32'd3);
        write_mb(1, 11'h7FF, 4'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1); // R5 ignored
        release_frame();
        accept_frame();
        chk("R6 lower id in slot 2 wins", 32'(tx_idx), 32'd2);
        release_frame();
        accept_frame();
        chk("R5 slot 1 kept original id", 32'(tx_id), 32'h200);
        release_frame();
        repeat (3) @(negedge clk);
        chk("R8 nothing offered when empty", 32'(tx_valid), 32'd0);
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        chk("R9 stray done ignored", 32'({tx_valid, mb_empty}), 32'h7);

        // directed: tie on identifier, then request order beats identifier
        write_mb(0, 11'h050, 4'd3, 32'h5, 32'h6, 1'b1);
        accept_frame();
        write_mb(2, 11'h080, 4'd4, 32'h7, 32'h8, 1'b1);
        write_mb(1, 11'h080, 4'd5, 32'h9, 32'hA, 1'b1);
        release_frame();
        accept_frame();
        chk("R6 tie goes to lower index", 32'(tx_idx), 32'd1);
        write_mb(0, 11'h001, 4'd6, 32'hB, 32'hC, 1'b1);
        cfg_fifo_order = 1'b1; // R10 sampled at pick
        release_frame();
        accept_frame();
        chk("R7 older request beats lower id", 32'(tx_idx), 32'd2);
        release_frame();
        accept_frame();
        release_frame();

        // random rounds
        for (int it = 0; it < 250; it++) begin
            if (m_cur < 0) begin
                if (exp_pick(cfg_fifo_order) < 0)
                    write_mb(int'(exp_free()), 11'($urandom), 4'($urandom % 9),
                             $urandom, $urandom, 1'b1);
                accept_frame();
            end
            cfg_fifo_order = 1'($urandom);
            for (int k = 0; k < int'($urandom % 4); k++)
                write_mb(int'($urandom % 3), 11'($urandom % 16), 4'($urandom % 9),
                         $urandom, $urandom, ($urandom % 5) != 0);
            release_frame();
            if (exp_pick(cfg_fifo_order) >= 0) accept_frame();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule